// File: doc/BRIEF.md
# Cartridge Bank Mapper with Interrupt Counter

This block sits on the write side of an 8-bit CPU cartridge bus and turns writes in the upper half of the address space (address bit 15 set) into bank numbers for program ROM, work RAM and character memory. It also drives a nametable mirroring select and a cycle-counting interrupt. Address bits [14:12] pick one of eight 4K write pages. Four pages each load one nibble of a 16-bit reload value. One page controls the counter and one acknowledges it. The last two pages hold an indirect select register and the bank-write port.

The interrupt counter counts up once on each cycle in which `cpu_tick` is high, provided it is enabled. When it steps past 0xFFFF it reloads from the reload value and raises `irq`, which stays high until software acknowledges it.

Each program bank number is five bits wide. Its low nibble comes through the select register. Its bit 4 comes through a separate address-coded write. Writes are single-cycle strobes, and the block never stalls the bus. There is no ready signal, and a write is taken in the cycle in which `wr_en` is high.

Top module: `cart_irq_mapper`

## Requirements
- R1: A write to page n (address 0x8000 + n*0x1000, n = 0..3) copies data[3:0] into bits [4n+3:4n] of the 16-bit reload value and leaves the other three nibbles unchanged.
- R2: A write to 0xC000-0xCFFF stores the data byte as the counter control and clears `irq`. If data[3:0] is nonzero, the counter is enabled and loaded from the reload value. If data[3:0] is zero, the counter stops and holds its value.
- R3: A write to 0xD000-0xDFFF clears `irq` and has no other effect on the counter.
- R4: While the counter is enabled, each cycle with `cpu_tick` high adds one to it. The tick that finds 0xFFFF reloads the counter from the reload value and sets `irq`. `irq` then stays high until a write to 0xC000-0xCFFF or 0xD000-0xDFFF.
- R5: A write to 0xE000-0xEFFF stores the select byte. On a write to 0xF000-0xFFFF, slot = select[3:0] - 1 (4-bit wrap). For slot 0, 1 or 2, bits [3:0] of program bank `slot` (the 0x8000, 0xA000 or 0xC000 window) take data[3:0] and bit 4 is kept.
- R6: On a write to 0xF000-0xFFFF with slot 3 (select = 4), the work-RAM bank takes the whole data byte. Slot 15 (select = 0) and slots 4 to 14 change no bank through the select path.
- R7: On a write to 0xF000-0xFFFF with address bits [11:10] = 00 and address[1:0] = k < 3, bit 4 of program bank k takes data[4] and its bits [3:0] are kept. With k = 3, no bit 4 changes. This update may land on the same bank as the select path in the same write.
- R8: On a write to 0xF000-0xFFFF with address bits [11:10] = 10, `mirror_vert` takes data[0] (1 = vertical, 0 = horizontal).
- R9: On a write to 0xF000-0xFFFF with address bits [11:10] = 11, character bank address[2:0] takes the whole data byte.
- R10: On a write to 0xF000-0xFFFF with address bits [11:10] = 01, only the select-path update happens.
- R11: Reset clears the counter, the reload value, the control, the select register, every bank number, `mirror_vert` and `irq`.
- R12: If an acknowledge write and a wrapping tick fall in the same cycle, `irq` stays low and the counter still reloads.
- R13: Writes with address bit 15 clear change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_tick | input | 1 | One-cycle enable per CPU cycle; clocks the counter |
| prg_banks | output | 15 | Three 5-bit program bank numbers; slot k at bits [5k+4:5k] |
| wram_bank | output | 8 | Work-RAM bank number |
| chr_banks | output | 64 | Eight 1K character bank numbers; bank c at bits [8c+7:8c] |
| mirror_vert | output | 1 | 1 = vertical mirroring, 0 = horizontal |
| irq | output | 1 | Level interrupt request, active high |

## Verification
The counter value never appears at a port, so the counter is observed only through the moment at which `irq` rises. The bench loads reload values just below 0xFFFF so that a wrap needs only a handful of ticks, and it changes a single nibble between wraps to show that the other nibbles survive. The hardest case is an acknowledge write that arrives in the same cycle as the wrapping tick. The bench sets the reload value to 0xFFFF, so the counter sits one tick from a wrap, and then drives the acknowledge and `cpu_tick` on the same clock edge. One further tick then shows that the reload still took place.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  localparam int CNT_W     = 16;
  localparam int NIB_W     = 4;
  localparam int PRG_SLOTS = 3;
  localparam int CHR_SLOTS = 8;
  localparam int BANK_W    = 5;
  localparam int BYTE_W    = 8;

  // Page code is address bits [14:12]; order matters for the nibble index
  typedef enum logic [2:0] {
    PG_NIB0   = 3'd0,
    PG_NIB1   = 3'd1,
    PG_NIB2   = 3'd2,
    PG_NIB3   = 3'd3,
    PG_CTL    = 3'd4,
    PG_ACK    = 3'd5,
    PG_SEL    = 3'd6,
    PG_BANK   = 3'd7
  } page_e;

  typedef struct packed {
    logic        vld;
    page_e       page;
    logic [11:0] off;
    logic [7:0]  data;
  } wr_cmd_t;
endpackage

// File: rtl/cart_irq_timer.sv
module cart_irq_timer
  import cart_map_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic    clk,
  input  logic    rst_n,
  input  wr_cmd_t cmd,
  input  logic    tick,
  output logic    irq
);
  localparam int NIBS = W / NIB_W;

  logic [W-1:0] reload_q, reload_d;
  logic [W-1:0] count_q, count_d;
  logic [7:0]   ctl_q;
  logic         irq_q, irq_d;
  logic         ctl_wr, ack_wr, running, wrap;
  logic [2:0]   nib_idx;

  assign nib_idx = 3'(cmd.page);
  assign ctl_wr  = cmd.vld && (cmd.page == PG_CTL);
  assign ack_wr  = cmd.vld && (cmd.page == PG_ACK);
  assign running = |ctl_q[3:0];
  assign wrap    = running && tick && (count_q == {W{1'b1}});

  always_comb begin
    reload_d = reload_q;
    if (cmd.vld && (int'(nib_idx) < NIBS))
      reload_d[int'(nib_idx)*NIB_W +: NIB_W] = cmd.data[NIB_W-1:0];
  end

  always_comb begin
    count_d = count_q;
    if (ctl_wr) begin
      if (|cmd.data[3:0]) count_d = reload_q;
    end else if (running && tick) begin
      count_d = wrap ? reload_q : count_q + 1'b1;
    end
  end

  always_comb begin
    irq_d = irq_q;
    if (ctl_wr || ack_wr) irq_d = 1'b0;
    else if (wrap)        irq_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      count_q  <= '0;
      ctl_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      reload_q <= reload_d;
      count_q  <= count_d;
      irq_q    <= irq_d;
      if (ctl_wr) ctl_q <= cmd.data;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/cart_bank_file.sv
module cart_bank_file
  import cart_map_pkg::*;
#(
  parameter int NPRG = PRG_SLOTS,
  parameter int NCHR = CHR_SLOTS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  wr_cmd_t                cmd,
  output logic [NPRG*BANK_W-1:0] prg_banks,
  output logic [BYTE_W-1:0]      wram_bank,
  output logic [NCHR*BYTE_W-1:0] chr_banks,
  output logic                   mirror_vert
);
  localparam int CSEL_W = $clog2(NCHR);

  logic [7:0] sel_q;
  logic [3:0] slot;
  logic       bank_wr;
  logic [1:0] mode;

  assign bank_wr = cmd.vld && (cmd.page == PG_BANK);
  assign slot    = sel_q[3:0] - 4'd1;
  assign mode    = cmd.off[11:10];

  always_ff @(posedge clk) begin
    if (!rst_n)                               sel_q <= '0;
    else if (cmd.vld && cmd.page == PG_SEL)   sel_q <= cmd.data;
  end

  for (genvar g = 0; g < NPRG; g++) begin : g_prg
    logic [3:0] lo_q;
    logic       hi_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= 1'b0;
      end else begin
        if (bank_wr && slot == 4'(g)) lo_q <= cmd.data[3:0];
        if (bank_wr && mode == 2'b00 && cmd.off[1:0] == 2'(g)) hi_q <= cmd.data[4];
      end
    end
    assign prg_banks[g*BANK_W +: BANK_W] = {hi_q, lo_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wram_bank   <= '0;
      mirror_vert <= 1'b0;
    end else begin
      if (bank_wr && slot == 4'(NPRG)) wram_bank <= cmd.data;
      if (bank_wr && mode == 2'b10)    mirror_vert <= cmd.data[0];
    end
  end

  for (genvar c = 0; c < NCHR; c++) begin : g_chr
    logic [BYTE_W-1:0] bank_q;
    always_ff @(posedge clk) begin
      if (!rst_n) bank_q <= '0;
      else if (bank_wr && mode == 2'b11 && cmd.off[CSEL_W-1:0] == CSEL_W'(c))
        bank_q <= cmd.data;
    end
    assign chr_banks[c*BYTE_W +: BYTE_W] = bank_q;
  end
endmodule

// File: rtl/cart_irq_mapper.sv
module cart_irq_mapper
  import cart_map_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [15:0]                 wr_addr,
  input  logic [7:0]                  wr_data,
  input  logic                        cpu_tick,
  output logic [PRG_SLOTS*BANK_W-1:0] prg_banks,
  output logic [BYTE_W-1:0]           wram_bank,
  output logic [CHR_SLOTS*BYTE_W-1:0] chr_banks,
  output logic                        mirror_vert,
  output logic                        irq
);
  wr_cmd_t cmd;

  always_comb begin
    cmd.vld  = wr_en && wr_addr[15];
    cmd.page = page_e'(wr_addr[14:12]);
    cmd.off  = wr_addr[11:0];
    cmd.data = wr_data;
  end

  cart_irq_timer #(.W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd),
    .tick  (cpu_tick),
    .irq   (irq)
  );

  cart_bank_file #(.NPRG(PRG_SLOTS), .NCHR(CHR_SLOTS)) u_banks (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .prg_banks   (prg_banks),
    .wram_bank   (wram_bank),
    .chr_banks   (chr_banks),
    .mirror_vert (mirror_vert)
  );
endmodule

// File: rtl/cart_irq_mapper_chk.sv
module cart_irq_mapper_chk
  import cart_map_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [15:0]                 wr_addr,
  input logic [7:0]                  wr_data,
  input logic                        cpu_tick,
  input logic [PRG_SLOTS*BANK_W-1:0] prg_banks,
  input logic [BYTE_W-1:0]           wram_bank,
  input logic [CHR_SLOTS*BYTE_W-1:0] chr_banks,
  input logic                        mirror_vert,
  input logic                        irq
);
  // R3
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15:12] == 4'hD) |=> !irq);

  // R2
  ctl_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15:12] == 4'hC) |=> !irq);

  // R4
  irq_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cpu_tick));

  // R4
  irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_en) |=> irq);

  // R13
  low_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || !wr_addr[15]) |=> ($stable(prg_banks) && $stable(chr_banks)
                                  && $stable(wram_bank) && $stable(mirror_vert)));

  // R8
  mirror_only_bank_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr[15:12] == 4'hF) |=> $stable(mirror_vert));
endmodule

bind cart_irq_mapper cart_irq_mapper_chk u_chk (.*);

// File: tb/cart_irq_mapper_test.sv
module cart_irq_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cpu_tick = 1'b0;
  logic [14:0] prg_banks;
  logic [7:0]  wram_bank;
  logic [63:0] chr_banks;
  logic        mirror_vert;
  logic        irq;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cart_irq_mapper uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_tick(cpu_tick), .prg_banks(prg_banks), .wram_bank(wram_bank),
    .chr_banks(chr_banks), .mirror_vert(mirror_vert), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cpu_tick = 1'b1;
    end
    @(negedge clk);
    cpu_tick = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_reset();
    do_reset();
    check("R11 prg", 64'(prg_banks), 64'h0);
    check("R11 wram", 64'(wram_bank), 64'h0);
    check("R11 chr", chr_banks, 64'h0);
    check("R11 mirror", 64'(mirror_vert), 64'h0);
    check("R11 irq", 64'(irq), 64'h0);
  endtask

  task automatic test_banks();
    wr(16'hE000, 8'h01);
    wr(16'hF400, 8'h1A);
    check("R5/R10 prg low nibble only", 64'(prg_banks), 64'h000A);
    check("R10 chr untouched", chr_banks, 64'h0);
    check("R10 mirror untouched", 64'(mirror_vert), 64'h0);
    wr(16'hE000, 8'h02);
    wr(16'hF000, 8'h13);
    check("R7 bit4 to slot0, R5 low to slot1", 64'(prg_banks), 64'h007A);
    wr(16'hE000, 8'h00);
    wr(16'hF003, 8'h1F);
    check("R7 k=3 ignored, R6 select 0 ignored", 64'(prg_banks), 64'h007A);
    wr(16'hE000, 8'h03);
    wr(16'hF002, 8'h07);
    check("R5 R7 same bank both paths", 64'(prg_banks), 64'h1C7A);
    wr(16'hE000, 8'h04);
    wr(16'hF800, 8'h5B);
    check("R6 wram byte", 64'(wram_bank), 64'h5B);
    check("R8 mirror vertical", 64'(mirror_vert), 64'h1);
    check("R6 prg untouched by wram slot", 64'(prg_banks), 64'h1C7A);
    wr(16'hE000, 8'h05);
    wr(16'hF001, 8'h1F);
    check("R6 slot4 no low write, R7 bit4 slot1", 64'(prg_banks), 64'h1E7A);
    check("R6 wram kept", 64'(wram_bank), 64'h5B);
    wr(16'hE000, 8'h00);
    wr(16'hF800, 8'h02);
    check("R8 mirror horizontal", 64'(mirror_vert), 64'h0);
    wr(16'hFC05, 8'hA5);
    wr(16'hFC0F, 8'h3C);
    check("R9 chr banks", chr_banks, 64'h3C00_A500_0000_0000);
  endtask

  task automatic test_low_ignored();
    wr(16'h6001, 8'h04);
    wr(16'h7C01, 8'h77);
    wr(16'h7800, 8'h01);
    check("R13 chr", chr_banks, 64'h3C00_A500_0000_0000);
    check("R13 mirror", 64'(mirror_vert), 64'h0);
    check("R13 prg", 64'(prg_banks), 64'h1E7A);
    check("R13 wram", 64'(wram_bank), 64'h5B);
  endtask

  task automatic test_counter();
    wr(16'h8000, 8'hFE);
    wr(16'h9000, 8'h0F);
    wr(16'hA000, 8'hAF);
    wr(16'hB000, 8'h0F);
    wr(16'hC000, 8'h01);
    check("R2 enable no irq", 64'(irq), 64'h0);
    ticks(1);
    check("R4 not yet wrapped", 64'(irq), 64'h0);
    ticks(1);
    check("R4 wrap raises irq", 64'(irq), 64'h1);
    wr(16'h8000, 8'h0C);
    check("R4 irq held over latch write", 64'(irq), 64'h1);
    ticks(2);
    check("R4 irq held over ticks", 64'(irq), 64'h1);
    wr(16'hD000, 8'h00);
    check("R3 ack clears", 64'(irq), 64'h0);
    ticks(3);
    check("R1 R3 count kept", 64'(irq), 64'h0);
    ticks(1);
    check("R4 second wrap", 64'(irq), 64'h1);
    wr(16'hD000, 8'h00);
    ticks(3);
    check("R1 nibble0 only: FFFC before wrap", 64'(irq), 64'h0);
    ticks(1);
    check("R1 FFFC wraps after 4", 64'(irq), 64'h1);
    wr(16'hC0F0, 8'hF0);
    check("R2 ctl write clears", 64'(irq), 64'h0);
    ticks(20);
    check("R2 zero low nibble stops", 64'(irq), 64'h0);
  endtask

  task automatic test_ack_on_wrap();
    wr(16'h8000, 8'h0F);
    wr(16'hC000, 8'h02);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'hD000; wr_data = 8'h00; cpu_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cpu_tick = 1'b0;
    check("R12 ack wins over wrap", 64'(irq), 64'h0);
    ticks(1);
    check("R12 reload happened", 64'(irq), 64'h1);
    do_reset();
    check("R11 irq cleared by reset", 64'(irq), 64'h0);
    check("R11 banks cleared", chr_banks, 64'h0);
  endtask

  initial begin
    test_reset();
    test_banks();
    test_low_ignored();
    test_counter();
    test_ack_on_wrap();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R4 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule